// File: doc/BRIEF.md
# Line-Granular Stride Prefetch Detector

This block watches the demand loads of a core and turns each load byte address into a 64-byte line address. Only the line address is used. It tracks runs of line addresses, one run per 4 KiB page, in a small table of trackers. When a run steps by the same nonzero number of lines again, the tracker is trained. The block then issues prefetch requests for the next lines along that step, going forward or backward. The byte offset inside a line is never looked at. A run that walks backwards inside each line while moving up one line at a time therefore trains as a forward stream.

Prefetch requests leave on a valid/ready port as line addresses. A two-entry queue holds them while the consumer stalls. Candidates that arrive while the queue is full are dropped. A static mode input limits training to loads flagged as misses. The same line-granular rule then applies to that filtered stream.

A two-state issue machine produces the candidates. In `ST_IDLE` it waits. On a training event it takes the transition *load* into `ST_ISSUE`, from either state, and stores the base line, the step and the page. Each cycle in `ST_ISSUE` offers one candidate. It takes the transition *finish* back to `ST_IDLE` in two cases: after the configured distance of candidates, or as soon as the next candidate would leave the base page.

Top module: `line_stream_prefetcher`

## Requirements
- R1: The line address is the byte address shifted right by 6 bits. Prefetch outputs carry line addresses (bits 31:6 of a byte address).
- R2: A load to the same line as the tracker's last line, at any offset, changes no tracker state and issues no prefetch.
- R3: A tracker trains on the third load in a page whose line step equals the previous step. That step is nonzero. At that load the block issues line+step and then line+2·step, in that order.
- R4: The step may be several lines and may be negative, so issued lines may skip lines or descend.
- R5: Offsets that decrease inside each line while line addresses rise by one train a forward stream.
- R6: With `miss_only_i`=1, loads with `req_miss_i`=0 are ignored for training. The filtered loads follow R1–R3.
- R7: The table has 4 trackers, each keyed by the 4 KiB page (line bits 25:6). A load to an untracked page replaces the least recently updated tracker. The new tracker starts with no step.
- R8: Issue stops at the first candidate whose page differs from the training load's page.
- R9: Up to 2 prefetches wait in a queue. `pf_line_o` holds while `pf_valid_o` is high and `pf_ready_i` is low. Candidates that arrive when the queue is full are dropped.
- R10: After reset, `pf_valid_o` is low and no tracker holds a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_only_i | input | 1 | Train only on loads flagged as misses |
| req_valid_i | input | 1 | Demand load observed this cycle |
| req_addr_i | input | 32 | Load byte address |
| req_miss_i | input | 1 | Load missed in the observed cache |
| pf_valid_o | output | 1 | Prefetch request available |
| pf_ready_i | input | 1 | Consumer accepts the request |
| pf_line_o | output | 26 | Line address to prefetch |

## Verification
Some properties are checked on every cycle:
- a same-line load leaves the tracker table untouched;
- training only follows an earlier matching step;
- the issue machine never offers more candidates than the distance allows and leaves `ST_ISSUE` at a page crossing;
- the queue never overfills and holds its head steady under backpressure.

Other behaviour only the bench scenarios can show. These are the exact prefetched lines for interleaved backward offsets, for multi-line and negative strides, and under the miss filter. They also include the least-recently-used choice of victim, and which candidates are lost while the queue is full.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } issue_state_e;
endpackage

// File: rtl/lsp_tracker_table.sv
module lsp_tracker_table #(
    parameter int NUM_TRK    = 4,
    parameter int LINE_W     = 26,
    parameter int PAGE_SHIFT = 6,
    parameter int CONF_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic [LINE_W-1:0] acc_line_i,
    output logic              train_o,
    output logic [LINE_W-1:0] train_line_o,
    output logic [LINE_W-1:0] train_delta_o
);
    localparam int IDX_W = (NUM_TRK > 1) ? $clog2(NUM_TRK) : 1;
    localparam logic [CONF_W-1:0] CONF_MAX   = '1;
    localparam logic [CONF_W-1:0] CONF_TRAIN = CONF_W'(2);
    localparam logic [IDX_W-1:0]  OLDEST     = IDX_W'(NUM_TRK - 1);

    logic [NUM_TRK-1:0]             vld_q;
    logic [NUM_TRK-1:0][LINE_W-1:0] last_q;
    logic [NUM_TRK-1:0][LINE_W-1:0] delta_q;
    logic [NUM_TRK-1:0][CONF_W-1:0] conf_q;
    logic [NUM_TRK-1:0][IDX_W-1:0]  age_q;
    logic [NUM_TRK-1:0]             match;

    logic              hit, same_line, delta_eq, update;
    logic [IDX_W-1:0]  hit_idx, victim_idx, touch_idx;
    logic [LINE_W-1:0] line_delta;
    logic [CONF_W-1:0] conf_next;

    // one page comparator per tracker
    for (genvar g = 0; g < NUM_TRK; g++) begin : g_match
        assign match[g] = vld_q[g] &&
            (last_q[g][LINE_W-1:PAGE_SHIFT] == acc_line_i[LINE_W-1:PAGE_SHIFT]);
    end

    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        victim_idx = '0;
        for (int i = NUM_TRK - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
        end
        same_line  = hit && (last_q[hit_idx] == acc_line_i);
        line_delta = acc_line_i - last_q[hit_idx];
        delta_eq   = hit && (line_delta == delta_q[hit_idx]);
        if (delta_eq)
            conf_next = (conf_q[hit_idx] == CONF_MAX) ? CONF_MAX : conf_q[hit_idx] + 1'b1;
        else
            conf_next = CONF_W'(1);
        update     = acc_valid_i && !same_line;
        touch_idx  = hit ? hit_idx : victim_idx;
    end

    assign train_o       = update && hit && (conf_next >= CONF_TRAIN);
    assign train_line_o  = acc_line_i;
    assign train_delta_o = line_delta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            last_q  <= '0;
            delta_q <= '0;
            conf_q  <= '0;
            for (int i = 0; i < NUM_TRK; i++) age_q[i] <= IDX_W'(i);
        end else if (update) begin
            for (int i = 0; i < NUM_TRK; i++) begin
                if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + 1'b1;
            end
            vld_q[touch_idx]  <= 1'b1;
            last_q[touch_idx] <= acc_line_i;
            if (hit) begin
                delta_q[touch_idx] <= line_delta;
                conf_q[touch_idx]  <= conf_next;
            end else begin
                delta_q[touch_idx] <= '0;
                conf_q[touch_idx]  <= '0;
            end
        end
    end

    // R2: a repeated line leaves the whole table unchanged
    p_same_line_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && same_line) |=> ($stable(last_q) && $stable(delta_q) && $stable(conf_q)));

    // R3: training needs a step already seen once before
    p_train_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        train_o |-> (conf_q[hit_idx] != '0));
endmodule

// File: rtl/lsp_issue_fsm.sv
module lsp_issue_fsm
    import lsp_pkg::*;
#(
    parameter int LINE_W     = 26,
    parameter int PAGE_SHIFT = 6,
    parameter int PF_DIST    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_i,
    input  logic [LINE_W-1:0] train_line_i,
    input  logic [LINE_W-1:0] train_delta_i,
    output logic              cand_valid_o,
    output logic [LINE_W-1:0] cand_line_o
);
    localparam int TAG_W = LINE_W - PAGE_SHIFT;
    localparam int CNT_W = $clog2(PF_DIST + 1);

    issue_state_e      state_q, state_d;
    logic [LINE_W-1:0] next_q, next_d, stride_q, stride_d;
    logic [TAG_W-1:0]  page_q, page_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              in_page;

    assign in_page = (next_q[LINE_W-1:PAGE_SHIFT] == page_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q   <= '0;
            stride_q <= '0;
            page_q   <= '0;
            cnt_q    <= '0;
        end else begin
            next_q   <= next_d;
            stride_q <= stride_d;
            page_q   <= page_d;
            cnt_q    <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        next_d   = next_q;
        stride_d = stride_q;
        page_d   = page_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                if (!in_page || cnt_q == CNT_W'(PF_DIST - 1)) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d  = cnt_q + 1'b1;
                    next_d = next_q + stride_q;
                end
            end
        endcase
        if (train_i) begin
            state_d  = ST_ISSUE;
            cnt_d    = '0;
            next_d   = train_line_i + train_delta_i;
            stride_d = train_delta_i;
            page_d   = train_line_i[LINE_W-1:PAGE_SHIFT];
        end
    end

    always_comb begin
        cand_valid_o = (state_q == ST_ISSUE) && in_page;
        cand_line_o  = next_q;
    end

    // R3: never more candidates than the distance
    p_issue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |-> (cnt_q < CNT_W'(PF_DIST)));

    // R8: crossing the page ends the issue
    p_page_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && !train_i && !in_page) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/lsp_pf_queue.sv
module lsp_pf_queue #(
    parameter int DEPTH = 2,
    parameter int W     = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic         out_valid_o,
    input  logic         out_ready_i,
    output logic [W-1:0] out_data_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, do_push, do_pop;

    assign full        = (count_q == CNT_W'(DEPTH));
    assign do_push     = push_i && !full;
    assign out_valid_o = (count_q != '0);
    assign do_pop      = out_valid_o && out_ready_i;
    assign out_data_o  = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data_i;
    end

    // R9: head held while the consumer stalls
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R9: occupancy bounded by the depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/line_stream_prefetcher.sv
module line_stream_prefetcher #(
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = 6,
    parameter int PAGE_LOG2 = 12,
    parameter int NUM_TRK   = 4,
    parameter int CONF_W    = 2,
    parameter int PF_DIST   = 2,
    parameter int Q_DEPTH   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_only_i,
    input  logic                        req_valid_i,
    input  logic [ADDR_W-1:0]           req_addr_i,
    input  logic                        req_miss_i,
    output logic                        pf_valid_o,
    input  logic                        pf_ready_i,
    output logic [ADDR_W-LINE_LOG2-1:0] pf_line_o
);
    localparam int LINE_W     = ADDR_W - LINE_LOG2;
    localparam int PAGE_SHIFT = PAGE_LOG2 - LINE_LOG2;

    logic              acc_valid;
    logic [LINE_W-1:0] acc_line;
    logic              train;
    logic [LINE_W-1:0] train_line, train_delta;
    logic              cand_valid;
    logic [LINE_W-1:0] cand_line;
    logic              offset_unused;

    assign acc_valid     = req_valid_i && (!miss_only_i || req_miss_i);
    assign acc_line      = req_addr_i[ADDR_W-1:LINE_LOG2];
    assign offset_unused = ^req_addr_i[LINE_LOG2-1:0];

    lsp_tracker_table #(
        .NUM_TRK(NUM_TRK), .LINE_W(LINE_W), .PAGE_SHIFT(PAGE_SHIFT), .CONF_W(CONF_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid), .acc_line_i(acc_line),
        .train_o(train), .train_line_o(train_line), .train_delta_o(train_delta)
    );

    lsp_issue_fsm #(
        .LINE_W(LINE_W), .PAGE_SHIFT(PAGE_SHIFT), .PF_DIST(PF_DIST)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .train_i(train), .train_line_i(train_line), .train_delta_i(train_delta),
        .cand_valid_o(cand_valid), .cand_line_o(cand_line)
    );

    lsp_pf_queue #(
        .DEPTH(Q_DEPTH), .W(LINE_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(cand_valid), .push_data_i(cand_line),
        .out_valid_o(pf_valid_o), .out_ready_i(pf_ready_i), .out_data_o(pf_line_o)
    );
endmodule

// File: tb/tb_line_stream_prefetcher.sv
`timescale 1ns/1ps
module tb_line_stream_prefetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_only = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_miss = 1'b0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [25:0] pf_line;

    always #2 clk = ~clk;

    line_stream_prefetcher dut (
        .clk(clk), .rst_n(rst_n), .miss_only_i(miss_only),
        .req_valid_i(req_valid), .req_addr_i(req_addr), .req_miss_i(req_miss),
        .pf_valid_o(pf_valid), .pf_ready_i(pf_ready), .pf_line_o(pf_line)
    );

    // {mode, miss, byte address, expected count, first line, second line}
    localparam int NV = 24;
    localparam logic [87:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0000_1020, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1018, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1008, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1000, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1060, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1058, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1048, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_10A0, 2'd2, 26'h43,  26'h44},
        {1'b0, 1'b0, 32'h0000_1098, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_10E0, 2'd2, 26'h44,  26'h45},
        {1'b0, 1'b0, 32'h0000_53C0, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_5300, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_5240, 2'd2, 26'h146, 26'h143},
        {1'b0, 1'b0, 32'h0000_8E40, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_8EC0, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_8F40, 2'd1, 26'h23F, 26'h0},
        {1'b1, 1'b1, 32'h0000_A000, 2'd0, 26'h0,   26'h0},
        {1'b1, 1'b0, 32'h0000_A040, 2'd0, 26'h0,   26'h0},
        {1'b1, 1'b1, 32'h0000_A080, 2'd0, 26'h0,   26'h0},
        {1'b1, 1'b0, 32'h0000_A0C0, 2'd0, 26'h0,   26'h0},
        {1'b1, 1'b1, 32'h0000_A100, 2'd2, 26'h286, 26'h288},
        {1'b0, 1'b0, 32'h0000_C000, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_1100, 2'd0, 26'h0,   26'h0},
        {1'b0, 1'b0, 32'h0000_A180, 2'd2, 26'h288, 26'h28A}
    };

    int errors = 0;
    int checks = 0;
    int log_n  = 0;
    bit done   = 1'b0;
    logic [25:0] log_q [64];

    // handshake monitor, half a cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready && log_n < 64) begin
            log_q[log_n] = pf_line;
            log_n++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic mode, input logic miss, input logic [31:0] addr);
        @(posedge clk); #1;
        miss_only = mode;
        req_valid = 1'b1;
        req_miss  = miss;
        req_addr  = addr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    function automatic string tag_of(input int v);
        if (v >= 1 && v <= 3) return "R2 same line";
        if (v == 7)           return "R3 R5 backward offsets forward lines";
        if (v < 10)           return "R1 R5 offset ignored";
        if (v < 13)           return "R4 stride of minus three";
        if (v < 16)           return "R8 page stop";
        if (v < 21)           return "R6 miss filter";
        return "R7 replacement order";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        // R10: reset state
        repeat (4) @(posedge clk);
        #1;
        check("R10 valid after reset", 32'(pf_valid), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            base = log_n;
            access(VEC[v][87], VEC[v][86], VEC[v][85:54]);
            check(tag_of(v), 32'(log_n - base), 32'(VEC[v][53:52]));
            if (VEC[v][53:52] >= 2'd1 && log_n > base)
                check(tag_of(v), 32'(log_q[base]), 32'(VEC[v][51:26]));
            if (VEC[v][53:52] == 2'd2 && log_n > base + 1)
                check(tag_of(v), 32'(log_q[base + 1]), 32'(VEC[v][25:0]));
        end

        // R9: backpressure, hold and drop
        @(posedge clk); #1;
        pf_ready = 1'b0;
        access(1'b0, 1'b0, 32'h0000_E000);
        access(1'b0, 1'b0, 32'h0000_E040);
        access(1'b0, 1'b0, 32'h0000_E080);
        check("R9 queued valid", 32'(pf_valid), 32'd1);
        check("R9 queued head", 32'(pf_line), 32'h383);
        access(1'b0, 1'b0, 32'h0000_E0C0);
        check("R9 head held while stalled", 32'(pf_line), 32'h383);
        base = log_n;
        pf_ready = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check("R9 drained count, extra dropped", 32'(log_n - base), 32'd2);
        if (log_n >= base + 2) begin
            check("R9 first drained", 32'(log_q[base]), 32'h383);
            check("R9 second drained", 32'(log_q[base + 1]), 32'h384);
        end
        check("R9 queue empty", 32'(pf_valid), 32'd0);

        // R10: reset clears the trackers
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R10 valid in reset", 32'(pf_valid), 32'd0);
        rst_n = 1'b1;
        base = log_n;
        access(1'b0, 1'b0, 32'h0000_E100);
        check("R10 no stream after reset", 32'(log_n - base), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule